// File: doc/BRIEF.md
# Boot Shadow ROM Address Controller

This block sits between an 8-bit processor's address bus and the memory arrays of a machine whose boot ROM lives high in the address space, from D800 to FFFF. A processor of this class starts fetching at address 0000 after reset. To make that work, the block keeps a mirror of the ROM's first page in the lowest 256-byte page after a system clear. Every access to 00xx is steered to the ROM at D8xx, and the low address byte is kept.

The boot code ends the mirror with a write to the control port at F3. That write only arms the removal. The following fetches in the low page still come from the ROM until the code jumps into the ROM's physical range. The first memory read at D800 or above then drops the mirror, and RAM answers from 0000 to D7FF. A later control write can switch the ROM out entirely, so that RAM covers the whole 64K space. A processor reset alone never brings the mirror or the ROM back. Only the external clear input does that, and it also acts as the power-up clear.

All outputs are combinational decodes of the current bus cycle and the mapping state. No data stream passes through the block, so there is no valid/ready interface and no back-pressure. The strobes are plain, level-sensitive bus qualifiers sampled on each clock.

Top module: `boot_shadow_ctl`

## Requirements
- R1: In the cycle after external clear is released, a memory read with address 00xx asserts rom_sel and drives rom_addr = D800 | xx. A read at 0100 or above and below D800 goes to RAM. mirror_armed is 0.
- R2: While the ROM is enabled, a memory read in D800..FFFF asserts rom_sel, and rom_addr equals the CPU address.
- R3: An I/O write to port F3 with data bit 0 = 0, made while the mirror is active, sets mirror_armed from the next cycle. Low-page reads keep selecting the ROM while it is armed.
- R4: While armed, the first memory read in D800..FFFF is itself served by the ROM. From the next cycle the mirror is off and mirror_armed is 0, low-page reads go to RAM, and D800..FFFF still reads ROM.
- R5: An I/O write to port F3 with data bit 1 = 0 disables the ROM from the next cycle. Every read from 0000 to FFFF then selects RAM, and the mirror is off.
- R6: I/O writes to any port other than F3, and F3 writes with data bits 1 and 0 both 1, change no mapping.
- R7: While cpu_reset is high, neither select is asserted and I/O writes are ignored. Asserting and releasing cpu_reset restores neither the mirror nor the ROM.
- R8: A memory write never asserts rom_sel. It selects RAM at every address, including the ROM range and the mirrored page.
- R9: In every memory cycle outside cpu_reset, exactly one of rom_sel and ram_sel is high. In a cycle with no memory strobe, both are low.
- R10: External clear restores the boot state (ROM enabled, mirror active, not armed) from any state, including the armed state.
- R11: A port F3 write with bit 0 = 0 made after the mirror is already off leaves mirror_armed at 0 and the low page on RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| ext_clr | input | 1 | External clear / power-up, synchronous, active high |
| cpu_reset | input | 1 | Processor reset, active high; blocks selects and I/O writes |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | CPU address |
| rom_sel | output | 1 | ROM array select |
| ram_sel | output | 1 | RAM array select |
| rom_addr | output | 16 | Address to the ROM, with the mirror remap applied |
| mirror_armed | output | 1 | Mirror removal armed, waiting for a fetch in the ROM range |

## Verification
The hardest state to reach is the armed mirror. It exists only between an F3 write and the first read in the ROM range, and a careless stimulus either skips it or leaves it by accident. The vector table walks the boot sequence cycle by cycle: low-page reads, then the arming write, then further low-page reads, a write to an unrelated port and another mirrored read while armed, and only then the read at E000 that ends it. The directed tests return to the armed state on purpose to show that external clear removes it, and that a processor reset leaves the mirror and the ROM in place.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  // Meaning of the data bits written to the control port
  localparam int CTRL_KEEP_MIRROR_BIT = 0;  // 0 arms mirror removal
  localparam int CTRL_KEEP_ROM_BIT    = 1;  // 0 switches the ROM out

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;

  typedef struct packed {
    logic rom_on;
    logic mirror_on;
    logic armed;
  } map_state_t;

endpackage

// File: rtl/bsh_ctrl_port.sv
module bsh_ctrl_port
  import bsh_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CTRL_PORT = 8'hF3
) (
  input  logic              io_wr,
  input  logic              bus_hold,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  output logic              req_drop_mirror,
  output logic              req_drop_rom
);

  localparam logic [PORT_W-1:0] PORT_MATCH = PORT_W'(CTRL_PORT);

  logic hit;
  logic unused_data;

  assign hit = io_wr && !bus_hold && (io_port == PORT_MATCH);

  assign req_drop_mirror = hit && !io_data[CTRL_KEEP_MIRROR_BIT];
  assign req_drop_rom    = hit && !io_data[CTRL_KEEP_ROM_BIT];

  assign unused_data = ^io_data;

endmodule

// File: rtl/bsh_map_state.sv
module bsh_map_state
  import bsh_pkg::*;
(
  input  logic       clk,
  input  logic       ext_clr,
  input  logic       hold,
  input  logic       req_drop_mirror,
  input  logic       req_drop_rom,
  input  logic       rom_fetch,
  output map_state_t st
);

  map_state_t st_nxt;

  always_comb begin
    st_nxt = st;
    if (req_drop_rom) begin
      st_nxt.rom_on    = 1'b0;
      st_nxt.mirror_on = 1'b0;
      st_nxt.armed     = 1'b0;
    end else begin
      if (req_drop_mirror && st.mirror_on) st_nxt.armed = 1'b1;
      if (st.armed && rom_fetch) begin
        st_nxt.mirror_on = 1'b0;
        st_nxt.armed     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ext_clr) begin
      st.rom_on    <= 1'b1;
      st.mirror_on <= 1'b1;
      st.armed     <= 1'b0;
    end else begin
      st <= st_nxt;
    end
  end

  // R10: the clear always lands in the boot state
  assert_clear_boot_state_R10: assert property (@(posedge clk)
    $past(ext_clr) |-> (st.rom_on && st.mirror_on && !st.armed));

  // R3: removal can only be pending while the mirror is still there
  assert_armed_needs_mirror_R3: assert property (@(posedge clk) disable iff (ext_clr)
    st.armed |-> st.mirror_on);

  // R4: a fetch from the ROM range ends an armed mirror
  assert_fetch_drops_mirror_R4: assert property (@(posedge clk) disable iff (ext_clr)
    (st.armed && rom_fetch) |=> (!st.mirror_on && !st.armed));

  // R5: no mirror without the ROM
  assert_no_mirror_without_rom_R5: assert property (@(posedge clk) disable iff (ext_clr)
    !st.rom_on |-> !st.mirror_on);

  // R7: processor reset never alters the mapping
  assert_hold_keeps_map_R7: assert property (@(posedge clk) disable iff (ext_clr)
    hold |=> ($stable(st.rom_on) && $stable(st.mirror_on)));

endmodule

// File: rtl/bsh_addr_decode.sv
module bsh_addr_decode
  import bsh_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8,
  parameter int ROM_BASE  = 16'hD800,
  parameter bit REMAP_OR  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  cyc_kind_t         kind,
  input  map_state_t        st,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              rom_fetch,
  output logic [ADDR_W-1:0] rom_addr
);

  localparam int HI_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ROM_BASE);

  logic              in_low_page;
  logic              in_rom_range;
  logic              mirror_hit;
  logic [ADDR_W-1:0] mirrored;

  assign in_low_page  = (addr[ADDR_W-1:PAGE_BITS] == '0);
  assign in_rom_range = (addr >= BASE);
  assign mirror_hit   = st.mirror_on && in_low_page;

  generate
    if (REMAP_OR) begin : g_or_remap
      assign mirrored = addr | BASE;
    end else begin : g_splice_remap
      assign mirrored = {BASE[ADDR_W-1:PAGE_BITS], addr[PAGE_BITS-1:0]};
    end
  endgenerate

  assign rom_addr = mirror_hit ? mirrored : addr;

  always_comb begin
    rom_sel   = 1'b0;
    ram_sel   = 1'b0;
    rom_fetch = 1'b0;
    unique case (kind)
      CYC_READ: begin
        rom_fetch = st.rom_on && in_rom_range;
        rom_sel   = (st.rom_on && in_rom_range) || mirror_hit;
        ram_sel   = !rom_sel;
      end
      CYC_WRITE: ram_sel = 1'b1;
      default: ;
    endcase
  end

  logic unused_hi;
  assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b1;

endmodule

// File: rtl/boot_shadow_ctl.sv
module boot_shadow_ctl
  import bsh_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PORT_W    = 8,
  parameter int PAGE_BITS = 8,
  parameter int ROM_BASE  = 16'hD800,
  parameter int CTRL_PORT = 8'hF3,
  parameter bit REMAP_OR  = 1'b1
) (
  input  logic              clk,
  input  logic              ext_clr,
  input  logic              cpu_reset,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              mirror_armed
);

  cyc_kind_t  kind;
  map_state_t st;
  logic       req_drop_mirror;
  logic       req_drop_rom;
  logic       rom_fetch;

  always_comb begin
    if (cpu_reset)   kind = CYC_IDLE;
    else if (mem_rd) kind = CYC_READ;
    else if (mem_wr) kind = CYC_WRITE;
    else             kind = CYC_IDLE;
  end

  bsh_ctrl_port #(
    .PORT_W   (PORT_W),
    .DATA_W   (DATA_W),
    .CTRL_PORT(CTRL_PORT)
  ) u_port (
    .io_wr          (io_wr),
    .bus_hold       (cpu_reset),
    .io_port        (io_port),
    .io_data        (io_data),
    .req_drop_mirror(req_drop_mirror),
    .req_drop_rom   (req_drop_rom)
  );

  bsh_map_state u_state (
    .clk            (clk),
    .ext_clr        (ext_clr),
    .hold           (cpu_reset),
    .req_drop_mirror(req_drop_mirror),
    .req_drop_rom   (req_drop_rom),
    .rom_fetch      (rom_fetch),
    .st             (st)
  );

  bsh_addr_decode #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .ROM_BASE (ROM_BASE),
    .REMAP_OR (REMAP_OR)
  ) u_dec (
    .addr     (cpu_addr),
    .kind     (kind),
    .st       (st),
    .rom_sel  (rom_sel),
    .ram_sel  (ram_sel),
    .rom_fetch(rom_fetch),
    .rom_addr (rom_addr)
  );

  assign mirror_armed = st.armed;

  // R8: memory writes never reach the ROM
  assert_write_not_rom_R8: assert property (@(posedge clk) disable iff (ext_clr)
    (mem_wr && !mem_rd) |-> !rom_sel);

  // R9: one select per memory cycle, none otherwise
  assert_one_select_R9: assert property (@(posedge clk) disable iff (ext_clr)
    ((mem_rd || mem_wr) && !cpu_reset) |-> ($countones({rom_sel, ram_sel}) == 1));

  assert_idle_no_select_R9: assert property (@(posedge clk) disable iff (ext_clr)
    (!(mem_rd || mem_wr) || cpu_reset) |-> (!rom_sel && !ram_sel));

  // R1: a mirrored read always lands on the ROM's first page
  assert_low_page_to_rom_R1: assert property (@(posedge clk) disable iff (ext_clr)
    (rom_sel && (cpu_addr[ADDR_W-1:PAGE_BITS] == '0))
      |-> (rom_addr[PAGE_BITS-1:0] == cpu_addr[PAGE_BITS-1:0] && rom_addr >= ADDR_W'(ROM_BASE)));

endmodule

// File: tb/sim_boot_shadow_ctl.sv
`timescale 1ns/1ps
module sim_boot_shadow_ctl;

  logic        clk = 1'b0;
  logic        ext_clr = 1'b1;
  logic        cpu_reset = 1'b0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = 8'h00;
  logic [7:0]  io_data = 8'hFF;
  logic [15:0] cpu_addr = 16'h0000;
  logic        rom_sel, ram_sel, mirror_armed;
  logic [15:0] rom_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_shadow_ctl u0 (
    .clk(clk), .ext_clr(ext_clr), .cpu_reset(cpu_reset),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_wr(io_wr),
    .io_port(io_port), .io_data(io_data), .cpu_addr(cpu_addr),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .rom_addr(rom_addr),
    .mirror_armed(mirror_armed)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        iow;
    logic [7:0]  port;
    logic [7:0]  data;
    logic [15:0] addr;
    logic        erom;
    logic        eram;
    logic [15:0] eaddr;
    logic        earm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    //   rd  wr  iow port   data   addr      rom ram eaddr     arm req
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0000,1'b1,1'b0,16'hD800,1'b0,4'd1},  // R1
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0001,1'b1,1'b0,16'hD801,1'b0,4'd1},  // R1
    '{1'b0,1'b1,1'b0,8'h00,8'hFF,16'h0005,1'b0,1'b1,16'hD805,1'b0,4'd8},  // R8
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hD800,1'b1,1'b0,16'hD800,1'b0,4'd2},  // R2
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h1234,1'b0,1'b1,16'h1234,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0100,1'b0,1'b1,16'h0100,1'b0,4'd1},  // R1
    '{1'b0,1'b0,1'b1,8'hF3,8'hFE,16'h1000,1'b0,1'b0,16'h1000,1'b0,4'd3},  // R3
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0002,1'b1,1'b0,16'hD802,1'b1,4'd3},  // R3
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0003,1'b1,1'b0,16'hD803,1'b1,4'd3},  // R3
    '{1'b0,1'b0,1'b1,8'hF2,8'h00,16'h1000,1'b0,1'b0,16'h1000,1'b1,4'd6},  // R6
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0004,1'b1,1'b0,16'hD804,1'b1,4'd6},  // R6
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hE000,1'b1,1'b0,16'hE000,1'b1,4'd4},  // R4
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0006,1'b0,1'b1,16'h0006,1'b0,4'd4},  // R4
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hD7FF,1'b0,1'b1,16'hD7FF,1'b0,4'd4},  // R4
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hFFFF,1'b1,1'b0,16'hFFFF,1'b0,4'd2},  // R2
    '{1'b0,1'b0,1'b1,8'hF3,8'hFF,16'h1000,1'b0,1'b0,16'h1000,1'b0,4'd6},  // R6
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hF000,1'b1,1'b0,16'hF000,1'b0,4'd6},  // R6
    '{1'b0,1'b1,1'b0,8'h00,8'hFF,16'hF000,1'b0,1'b1,16'hF000,1'b0,4'd8},  // R8
    '{1'b0,1'b0,1'b1,8'hF3,8'hFE,16'h1000,1'b0,1'b0,16'h1000,1'b0,4'd11}, // R11
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd11}, // R11
    '{1'b0,1'b0,1'b1,8'hF3,8'hFD,16'h1000,1'b0,1'b0,16'h1000,1'b0,4'd5},  // R5
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hD800,1'b0,1'b1,16'hD800,1'b0,4'd5},  // R5
    '{1'b1,1'b0,1'b0,8'h00,8'hFF,16'hFFFF,1'b0,1'b1,16'hFFFF,1'b0,4'd5},  // R5
    '{1'b0,1'b0,1'b0,8'h00,8'hFF,16'h1000,1'b0,1'b0,16'h1000,1'b0,4'd9}   // R9
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic clr, input logic rst, input logic rd, input logic wr,
                       input logic iow, input logic [7:0] port, input logic [7:0] data,
                       input logic [15:0] addr);
    @(negedge clk);
    ext_clr = clr; cpu_reset = rst; mem_rd = rd; mem_wr = wr;
    io_wr = iow; io_port = port; io_data = data; cpu_addr = addr;
    #1;
  endtask

  task automatic expect_out(input string req, input logic erom, input logic eram,
                            input logic [15:0] eaddr, input logic earm);
    chk(rom_sel === erom, req, "rom_sel", 16'(rom_sel), 16'(erom));
    chk(ram_sel === eram, req, "ram_sel", 16'(ram_sel), 16'(eram));
    chk(rom_addr === eaddr, req, "rom_addr", rom_addr, eaddr);
    chk(mirror_armed === earm, req, "mirror_armed", 16'(mirror_armed), 16'(earm));
  endtask

  initial begin : watchdog
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) drive(1, 0, 0, 0, 0, 8'h00, 8'hFF, 16'h1000);

    // Table walk: boot handoff, ROM switch-out
    for (int i = 0; i < NV; i++) begin
      drive(0, 0, VEC[i].rd, VEC[i].wr, VEC[i].iow, VEC[i].port, VEC[i].data, VEC[i].addr);
      expect_out($sformatf("R%0d row %0d", VEC[i].req, i),
                 VEC[i].erom, VEC[i].eram, VEC[i].eaddr, VEC[i].earm);
    end

    // R7: ROM is off; cpu_reset blocks selects and brings nothing back
    for (int k = 0; k < 3; k++) begin
      drive(0, 1, 1, 0, 0, 8'h00, 8'hFF, 16'h0000);
      expect_out("R7 hold", 0, 0, 16'h0000, 0);
    end
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0000);
    expect_out("R7 after release, low page", 0, 1, 16'h0000, 0);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'hE000);
    expect_out("R7 after release, rom range", 0, 1, 16'hE000, 0);

    // R10: external clear brings the boot map back
    drive(1, 0, 0, 0, 0, 8'h00, 8'hFF, 16'h1000);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0042);
    expect_out("R10 mirror restored", 1, 0, 16'hD842, 0);

    // R7: I/O write during cpu_reset is ignored; mirror survives reset
    drive(0, 1, 0, 0, 1, 8'hF3, 8'h00, 8'h00);
    expect_out("R7 io during hold", 0, 0, 16'hD800, 0);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0010);
    expect_out("R7 mirror survives reset", 1, 0, 16'hD810, 0);

    // R10: clear from the armed state
    drive(0, 0, 0, 0, 1, 8'hF3, 8'hFE, 16'h1000);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0020);
    expect_out("R10 armed before clear", 1, 0, 16'hD820, 1);
    drive(1, 0, 0, 0, 0, 8'h00, 8'hFF, 16'h1000);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0020);
    expect_out("R10 armed cleared", 1, 0, 16'hD820, 0);

    // R8: write into the mirrored page goes to RAM
    drive(0, 0, 0, 1, 0, 8'h00, 8'hFF, 16'h0030);
    expect_out("R8 write in mirror", 0, 1, 16'hD830, 0);

    // R5: both bits low at once; ROM and mirror gone together
    drive(0, 0, 0, 0, 1, 8'hF3, 8'hFC, 16'h1000);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'h0000);
    expect_out("R5 both bits, low page", 0, 1, 16'h0000, 0);
    drive(0, 0, 1, 0, 0, 8'h00, 8'hFF, 16'hD900);
    expect_out("R5 both bits, rom range", 0, 1, 16'hD900, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule